// File: doc/BRIEF.md
# Periodic Supply-Reset Sampling Controller

This block decides when the supply-reset comparator, which detects brown-out and power-down conditions, is allowed to run. It also turns the comparator's verdict into a reset request. In Run mode, and whenever the low-power sampling enable is clear, the comparator stays enabled and any below-threshold indication raises the request on the next clock. In Stop or Standby with the enable set, the comparator is switched on only in short settle windows. A window opens once every `PERIOD_TICKS` slow ticks, which defaults to about 12 ms of a 32.768 kHz tick.

Inside a window the enable strobe stays high for `SETTLE_CYC` clocks. The comparator output is latched in the final cycle of the window. A supply dip that starts and ends between two windows is not seen, so it causes no reset. This is the intended price of the power saving. The request is sticky: once raised, only a reset of the block clears it. Each entry into a sampled low-power mode starts the period count again from zero.

Top module: `supply_sample_ctrl`

## Requirements
- R1: After reset, `rst_req` is 0 and, with `mode` at Run, `cmp_en` is 1.
- R2: With `ulp_en` at 0 in Stop (`mode`=2'b01) or Standby (`mode`=2'b10), `cmp_en` stays 1 and a `cmp_below` of 1 raises `rst_req` one clock later.
- R3: In Run (`mode`=2'b00) `cmp_en` is 1 and `cmp_below` raises `rst_req` one clock later, whatever `ulp_en` is.
- R4: With `ulp_en` at 1 in Stop or Standby, `cmp_en` is 0 except inside settle windows. A window opens on the clock edge that takes in the `PERIOD_TICKS`-th `tick` pulse counted since the mode was entered or since the previous window opened.
- R5: A settle window keeps `cmp_en` at 1 for exactly `SETTLE_CYC` consecutive clocks.
- R6: In sampled mode, `cmp_below` is looked at only in the last cycle of a window. If it is 1 there, `rst_req` is 1 from the next clock on. A value of 1 in earlier window cycles has no effect.
- R7: In sampled mode, a `cmp_below` pulse that falls wholly outside a window leaves `rst_req` at 0.
- R8: Once set, `rst_req` stays 1 until `rst_n` is asserted.
- R9: Leaving a sampled mode and entering it again restarts the tick count, so a full `PERIOD_TICKS` ticks pass before the next window.
- R10: The reserved `mode` code 2'b11 is treated as Run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ulp_en | input | 1 | Low-power sampling enable (control bit 7) |
| mode | input | 2 | Power mode: 00 Run, 01 Stop, 10 Standby, 11 Run |
| tick | input | 1 | One-clock pulse per slow-clock tick |
| cmp_below | input | 1 | Comparator result, 1 = supply below reset threshold |
| cmp_en | output | 1 | Comparator enable strobe |
| rst_req | output | 1 | Sticky supply-reset request |

## Verification
Suppose the tick counter is off by one or is not cleared on mode entry. Then the first rising edge of `cmp_en` lands one tick early or late, visible at the port within a few slow ticks of entering Stop. A window counter with a wrong length shows up as the number of clocks `cmp_en` stays high. If the latch point is wrong, a below-threshold indication in early window cycles raises `rst_req`, or one in the last cycle fails to. Because the request is sticky, a wrong capture stays visible until reset.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_STOP = 2'b01,
    MODE_STBY = 2'b10,
    MODE_RSVD = 2'b11
  } pmode_e;
endpackage

// File: rtl/ssc_period_cnt.sv
module ssc_period_cnt #(
  parameter int PERIOD_TICKS = 393
) (
  input  logic clk,
  input  logic rst_n,
  input  logic periodic,
  input  logic enter,
  input  logic tick,
  output logic fire
);
  localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    fire   = periodic && !enter && tick && (cnt_q == LAST);
    cnt_en = !periodic || enter || tick;
    cnt_d  = cnt_q;
    if (!periodic || enter || fire) cnt_d = '0;
    else if (tick)                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);  // R4
  AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> (cnt_q == '0));  // R9
endmodule

// File: rtl/ssc_settle_win.sv
module ssc_settle_win #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic periodic,
  input  logic start,
  output logic active,
  output logic last
);
  localparam int WW = $clog2(SETTLE_CYC + 1);
  localparam logic [WW-1:0] LOAD = WW'(SETTLE_CYC);

  logic [WW-1:0] win_q, win_d;
  logic          win_en;

  always_comb begin
    active = (win_q != '0);
    last   = (win_q == WW'(1));
    win_en = !periodic || start || active;
    win_d  = win_q;
    if (!periodic)           win_d = '0;
    else if (active)         win_d = win_q - 1'b1;
    else if (start)          win_d = LOAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && periodic) |=> active);  // R5
  AST_WIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);  // R5
endmodule

// File: rtl/ssc_req_latch.sv
module ssc_req_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic req
);
  logic req_q, req_d;

  always_comb req_d = req_q | set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> req);  // R8
endmodule

// File: rtl/supply_sample_ctrl.sv
module supply_sample_ctrl #(
  parameter int PERIOD_TICKS = 393,
  parameter int SETTLE_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ulp_en,
  input  logic [1:0] mode,
  input  logic       tick,
  input  logic       cmp_below,
  output logic       cmp_en,
  output logic       rst_req
);
  import ssc_pkg::*;

  logic [1:0] rsync_q;
  logic       rst_sync_n;
  logic       low_pwr, periodic, periodic_q, enter;
  logic       fire, win_active, win_last, req_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  always_comb begin
    low_pwr  = (pmode_e'(mode) == MODE_STOP) || (pmode_e'(mode) == MODE_STBY);
    periodic = ulp_en && low_pwr;
    enter    = periodic && !periodic_q;
    cmp_en   = !periodic || win_active;
    req_set  = periodic ? (win_last && cmp_below) : cmp_below;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) periodic_q <= 1'b0;
    else             periodic_q <= periodic;
  end

  ssc_period_cnt #(.PERIOD_TICKS(PERIOD_TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .periodic(periodic),
    .enter(enter), .tick(tick), .fire(fire)
  );

  ssc_settle_win #(.SETTLE_CYC(SETTLE_CYC)) u_win (
    .clk(clk), .rst_n(rst_sync_n), .periodic(periodic),
    .start(fire), .active(win_active), .last(win_last)
  );

  ssc_req_latch u_req (
    .clk(clk), .rst_n(rst_sync_n), .set(req_set), .req(rst_req)
  );

  AST_RUN_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode == 2'b00 || mode == 2'b11) |-> cmp_en);  // R3
  AST_OFF_CONTINUOUS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ulp_en |-> cmp_en);  // R2
  AST_REQ_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(rst_req) && $past(periodic)) |-> $past(win_last));  // R6
endmodule

// File: tb/tb_supply_sample_ctrl.sv
module tb_supply_sample_ctrl;
  localparam int PT = 4;
  localparam int SC = 3;

  logic clk = 1'b0;
  logic rst_n, ulp_en, tick, cmp_below;
  logic [1:0] mode;
  logic cmp_en, rst_req;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  supply_sample_ctrl #(.PERIOD_TICKS(PT), .SETTLE_CYC(SC)) dut (
    .clk(clk), .rst_n(rst_n), .ulp_en(ulp_en), .mode(mode),
    .tick(tick), .cmp_below(cmp_below), .cmp_en(cmp_en), .rst_req(rst_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ulp_en = 1'b0; mode = 2'b00; tick = 1'b0; cmp_below = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rst_req", rst_req, 1'b0);
    check("R1 cmp_en", cmp_en, 1'b1);
  endtask

  task automatic t_run();
    do_reset();
    ulp_en = 1'b1; mode = 2'b11;
    @(negedge clk);
    check("R10 cmp_en reserved", cmp_en, 1'b1);
    mode = 2'b00;
    @(negedge clk);
    check("R3 cmp_en", cmp_en, 1'b1);
    cmp_below = 1'b1;
    @(negedge clk);
    cmp_below = 1'b0;
    check("R3 rst_req", rst_req, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 sticky", rst_req, 1'b1);
  endtask

  task automatic t_cont_low();
    do_reset();
    mode = 2'b01;
    repeat (2) @(negedge clk);
    check("R2 cmp_en stop", cmp_en, 1'b1);
    mode = 2'b10;
    @(negedge clk);
    check("R2 cmp_en standby", cmp_en, 1'b1);
    cmp_below = 1'b1;
    @(negedge clk);
    cmp_below = 1'b0;
    check("R2 rst_req", rst_req, 1'b1);
  endtask

  task automatic t_periodic();
    int n;
    do_reset();
    ulp_en = 1'b1; mode = 2'b10;
    @(negedge clk);
    check("R4 idle", cmp_en, 1'b0);
    for (int i = 0; i < PT - 1; i++) begin
      cmp_below = (i == 1);
      pulse_tick();
      check("R4 before period", cmp_en, 1'b0);
    end
    cmp_below = 1'b0;
    @(negedge clk);
    check("R7 dip ignored", rst_req, 1'b0);
    pulse_tick();
    check("R4 window opens", cmp_en, 1'b1);
    n = 0;
    while (cmp_en === 1'b1 && n < 20) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != SC) begin
      errors++;
      $display("FAIL R5: actual=%0d expected=%0d", n, SC);
    end
    check("R7 no request", rst_req, 1'b0);
    for (int i = 0; i < PT; i++) pulse_tick();
    check("R4 second window", cmp_en, 1'b1);
    cmp_below = 1'b1;
    repeat (SC) @(negedge clk);
    cmp_below = 1'b0;
    check("R6 window closed", cmp_en, 1'b0);
    check("R6 latched below", rst_req, 1'b1);
  endtask

  task automatic t_early_only();
    do_reset();
    ulp_en = 1'b1; mode = 2'b01;
    @(negedge clk);
    for (int i = 0; i < PT; i++) pulse_tick();
    cmp_below = 1'b1;
    @(negedge clk);
    cmp_below = 1'b0;
    repeat (SC - 1) @(negedge clk);
    check("R6 early cycle ignored", rst_req, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    ulp_en = 1'b1; mode = 2'b01;
    @(negedge clk);
    pulse_tick();
    pulse_tick();
    mode = 2'b00;
    @(negedge clk);
    mode = 2'b01;
    @(negedge clk);
    for (int i = 0; i < PT - 1; i++) begin
      pulse_tick();
      check("R9 count restarted", cmp_en, 1'b0);
    end
    pulse_tick();
    check("R9 window after full period", cmp_en, 1'b1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_run();
    t_cont_low();
    t_periodic();
    t_early_only();
    t_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule